// File: doc/BRIEF.md
# TLB Lockdown Victim Selector

This block decides which slot of a 64-entry address translation buffer receives the next refill, and keeps track of which slots hold live translations. A programmable control word holds a floor index, a rotating replacement pointer and a keep-on-flush flag. Every refill lands in the slot named by the pointer, and the pointer then steps upward. When it reaches the top slot, it returns to the floor rather than to slot zero. Slots below the floor are therefore never replaced, which pins whatever was loaded into them.

The block also keeps a live bit and a keep bit for each slot. A whole-buffer invalidate clears every live slot except those that were loaded while the keep flag was set. An addressed invalidate clears a single slot, whatever its keep bit. Both kinds of invalidate send the pointer back to the floor and leave the floor unchanged. Tag and data storage, the table walker and instruction decoding sit outside this block. The instruction side and the data side each use their own instance.

Top module: `tlb_victim_ctrl`

## Requirements
- R1: The control word places the floor in bits 31:26, the replacement pointer in bits 25:20 and the keep flag in bit 0. Bits 19:1 always read as zero, and writes to them are ignored. A write takes effect on the next clock edge, and reads are combinational.
- R2: A refill sets the live bit of the slot named by `victim_idx`, and the pointer advances by one from the next cycle.
- R3: When a refill occurs with the pointer at 63, the pointer moves to the floor, not to 0. Once the pointer is at or above the floor, the slots below the floor are never refilled.
- R4: A whole-buffer invalidate clears the live bit of every slot whose keep bit is 0 and leaves slots with keep bit 1 live.
- R5: An addressed invalidate clears the live bit and the keep bit of the slot given by `inv_idx`, even when its keep bit is 1.
- R6: Any invalidate leaves the floor unchanged and loads the pointer with the floor.
- R7: A refill copies the keep flag in effect at that edge into the keep bit of the slot. A slot's keep bit is never 1 while its live bit is 0.
- R8: The floor and the pointer are written independently, and a pointer below the floor is allowed. For example, with floor 4 and pointer 3, the next refill goes to slot 3 and the pointer then becomes 4.
- R9: A refill requested in the same cycle as any invalidate is dropped: no slot is loaded, and the pointer is reloaded from the floor.
- R10: After reset, all live and keep bits are 0, and the floor, the pointer and the keep flag are 0.
- R11: When a control-word write coincides with a refill, the refill still uses the old pointer and old keep flag. The written floor, pointer and flag then replace the advanced pointer. A write also takes precedence over the pointer reload done by an invalidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| refill | input | 1 | Request to load the slot at `victim_idx` |
| victim_idx | output | 6 | Current replacement pointer |
| inv_all | input | 1 | Whole-buffer invalidate, sparing kept slots |
| inv_one | input | 1 | Addressed single-slot invalidate |
| inv_idx | input | 6 | Slot addressed by `inv_one` |
| live_vec | output | 64 | Live bit of each slot |
| keep_vec | output | 64 | Keep bit of each slot |

## Verification
Refills are run from a zero floor, from a raised floor with the pointer below it, and from a pointer near 63. These three cases separate plain incrementing, the lower-pointer start and the return to the floor rather than to zero. A long refill run with a raised floor shows that the pinned slots below the floor never change. Invalidates are applied to a mix of kept and unkept slots, alone and together with a refill or a control-word write. This separates keep-aware clearing from unconditional clearing and checks each ordering rule.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
  localparam int unsigned REG_W = 32;

  // per-cycle strobes after priority resolution
  typedef struct packed {
    logic wr;
    logic load;
    logic inv_any;
  } tlbv_ctl_t;
endpackage

// File: rtl/tlbv_rst_sync.sv
module tlbv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tlbv_lockreg.sv
module tlbv_lockreg
  import tlbv_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tlbv_ctl_t        ctl,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [IDX_W-1:0] floor_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             keep_o
);
  localparam int unsigned FLOOR_HI = REG_W - 1;
  localparam int unsigned PTR_HI   = REG_W - 1 - IDX_W;
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] floor_q, floor_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             keep_q, keep_d;
  logic             en;

  always_comb begin
    floor_d = floor_q;
    ptr_d   = ptr_q;
    keep_d  = keep_q;
    en      = 1'b0;
    if (ctl.wr) begin
      floor_d = wdata[FLOOR_HI -: IDX_W];
      ptr_d   = wdata[PTR_HI -: IDX_W];
      keep_d  = wdata[0];
      en      = 1'b1;
    end else if (ctl.inv_any) begin
      ptr_d = floor_q;
      en    = 1'b1;
    end else if (ctl.load) begin
      ptr_d = (ptr_q == TOP) ? floor_q : ptr_q + 1'b1;
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q <= '0;
      ptr_q   <= '0;
      keep_q  <= 1'b0;
    end else if (en) begin
      floor_q <= floor_d;
      ptr_q   <= ptr_d;
      keep_q  <= keep_d;
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[FLOOR_HI -: IDX_W] = floor_q;
    rdata[PTR_HI -: IDX_W]   = ptr_q;
    rdata[0]                 = keep_q;
  end

  assign floor_o = floor_q;
  assign ptr_o   = ptr_q;
  assign keep_o  = keep_q;

  AST_WRAP_TO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && !ctl.wr && ptr_q == TOP) |=> (ptr_q == $past(floor_q))); // R3

  AST_STAY_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && !ctl.wr && ptr_q >= floor_q) |=> (ptr_q >= floor_q)); // R3

  AST_INV_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.inv_any && !ctl.wr) |=> (ptr_q == $past(floor_q) && $stable(floor_q))); // R6
endmodule

// File: rtl/tlbv_slot_state.sv
module tlbv_slot_state #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [IDX_W-1:0]   load_idx,
  input  logic               load_keep,
  input  logic               inv_all,
  input  logic               inv_one,
  input  logic [IDX_W-1:0]   inv_idx,
  output logic [ENTRIES-1:0] live_o,
  output logic [ENTRIES-1:0] keep_o
);
  logic [ENTRIES-1:0] live_q, keep_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic live_d, keep_d, en;
    logic hit_inv, hit_load;

    assign hit_inv  = inv_one && (inv_idx == IDX_W'(i));
    assign hit_load = load && (load_idx == IDX_W'(i));

    always_comb begin
      live_d = live_q[i];
      keep_d = keep_q[i];
      en     = 1'b0;
      if (hit_inv) begin
        live_d = 1'b0;
        keep_d = 1'b0;
        en     = 1'b1;
      end else if (inv_all) begin
        live_d = keep_q[i] & live_q[i];
        keep_d = keep_q[i] & live_q[i];
        en     = 1'b1;
      end else if (hit_load) begin
        live_d = 1'b1;
        keep_d = load_keep;
        en     = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[i] <= 1'b0;
        keep_q[i] <= 1'b0;
      end else if (en) begin
        live_q[i] <= live_d;
        keep_q[i] <= keep_d;
      end
    end
  end

  assign live_o = live_q;
  assign keep_o = keep_q;

  AST_KEEP_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((keep_q & ~live_q) == '0)); // R7

  AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_one |=> !live_q[$past(inv_idx)]); // R5

  AST_ALL_SPARES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !inv_one) |=> (live_q == $past(live_q & keep_q))); // R4
endmodule

// File: rtl/tlb_victim_ctrl.sv
module tlb_victim_ctrl
  import tlbv_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               refill,
  output logic [IDX_W-1:0]   victim_idx,
  input  logic               inv_all,
  input  logic               inv_one,
  input  logic [IDX_W-1:0]   inv_idx,
  output logic [ENTRIES-1:0] live_vec,
  output logic [ENTRIES-1:0] keep_vec
);
  logic             rst_s_n;
  tlbv_ctl_t        ctl;
  logic [IDX_W-1:0] floor_w, ptr_w;
  logic             keep_w;

  tlbv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // any invalidate drops a coincident refill
  always_comb begin
    ctl.wr      = cfg_wr;
    ctl.inv_any = inv_all | inv_one;
    ctl.load    = refill & ~(inv_all | inv_one);
  end

  tlbv_lockreg #(.ENTRIES(ENTRIES)) u_reg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ctl     (ctl),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .floor_o (floor_w),
    .ptr_o   (ptr_w),
    .keep_o  (keep_w)
  );

  tlbv_slot_state #(.ENTRIES(ENTRIES)) u_slots (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (ctl.load),
    .load_idx  (ptr_w),
    .load_keep (keep_w),
    .inv_all   (inv_all),
    .inv_one   (inv_one),
    .inv_idx   (inv_idx),
    .live_o    (live_vec),
    .keep_o    (keep_vec)
  );

  assign victim_idx = ptr_w;

  AST_REFILL_LOADS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (refill && !inv_all && !inv_one) |=>
      (live_vec[$past(victim_idx)] && keep_vec[$past(victim_idx)] == $past(cfg_rdata[0]))); // R2

  AST_DROP_ON_INV: assert property (@(posedge clk) disable iff (!rst_s_n)
    (refill && inv_all && !inv_one) |=> ((live_vec & ~$past(live_vec)) == '0)); // R9
endmodule

// File: tb/sim_tlb_victim_ctrl.sv
module sim_tlb_victim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        refill = 1'b0;
  logic [5:0]  victim_idx;
  logic        inv_all = 1'b0;
  logic        inv_one = 1'b0;
  logic [5:0]  inv_idx = '0;
  logic [63:0] live_vec, keep_vec;

  int checks = 0;
  int errors = 0;

  // expected state, kept from the requirements
  logic [63:0] e_live = '0, e_keep = '0;
  logic [5:0]  e_floor = '0, e_ptr = '0;
  logic        e_flag = 1'b0;

  always #5 clk = ~clk;

  tlb_victim_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .refill(refill), .victim_idx(victim_idx),
    .inv_all(inv_all), .inv_one(inv_one), .inv_idx(inv_idx),
    .live_vec(live_vec), .keep_vec(keep_vec)
  );

  function automatic logic [31:0] word(input logic [5:0] f, input logic [5:0] p, input logic k);
    return {f, p, 19'b0, k};
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "rdata", {32'b0, cfg_rdata}, {32'b0, word(e_floor, e_ptr, e_flag)});
    check(tag, "victim", {58'b0, victim_idx}, {58'b0, e_ptr});
    check(tag, "live", live_vec, e_live);
    check(tag, "keep", keep_vec, e_keep);
  endtask

  // one clock of stimulus, expected update, then a check after the edge
  task automatic cyc(input logic wr, input logic [31:0] wd, input logic rf,
                     input logic ia, input logic io, input logic [5:0] ii, input string tag);
    logic go;
    @(negedge clk);
    cfg_wr = wr; cfg_wdata = wd; refill = rf; inv_all = ia; inv_one = io; inv_idx = ii;
    go = rf && !ia && !io;
    if (go) begin e_live[e_ptr] = 1'b1; e_keep[e_ptr] = e_flag; end
    if (ia) begin e_live = e_live & e_keep; e_keep = e_live; end
    if (io) begin e_live[ii] = 1'b0; e_keep[ii] = 1'b0; end
    if (wr) begin e_floor = wd[31:26]; e_ptr = wd[25:20]; e_flag = wd[0]; end
    else if (ia || io) e_ptr = e_floor;
    else if (go) e_ptr = (e_ptr == 6'd63) ? e_floor : e_ptr + 6'd1;
    @(posedge clk);
    #2;
    check_all(tag);
    cfg_wr = 1'b0; refill = 1'b0; inv_all = 1'b0; inv_one = 1'b0;
  endtask

  task automatic t_reset;
    check_all("R10");
  endtask

  task automatic t_register;
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1");
    check("R1", "all-ones read", {32'b0, cfg_rdata}, 64'hFFF0_0001);
    cyc(1, 32'h000F_FFFE, 0, 0, 0, 0, "R1");
    check("R1", "middle bits ignored", {32'b0, cfg_rdata}, 64'h0);
  endtask

  task automatic t_fill;
    cyc(1, word(0, 0, 0), 0, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0, "R2");
    check("R2", "slots 0..3 live", live_vec, 64'hF);
  endtask

  task automatic t_lower_ptr;
    cyc(1, word(4, 3, 1), 0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, "R8");
    check("R8", "pointer after slot 3", {58'b0, victim_idx}, 64'd4);
    check("R7", "slot 3 kept", {63'b0, keep_vec[3]}, 64'd1);
  endtask

  task automatic t_wrap;
    cyc(1, word(4, 62, 0), 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, "R3");
    check("R3", "wrap to floor", {58'b0, victim_idx}, 64'd4);
    for (int i = 0; i < 70; i++) cyc(0, 0, 1, 0, 0, 0, "R3");
    check("R3", "pinned slots 0..3", {60'b0, live_vec[3:0]}, 64'hF);
    check("R7", "slot 3 keep untouched", {63'b0, keep_vec[3]}, 64'd1);
  endtask

  task automatic t_inv_all;
    cyc(0, 0, 0, 1, 0, 0, "R4");
    check("R4", "only kept slot survives", live_vec, 64'h8);
    check("R6", "floor kept, pointer reloaded", {32'b0, cfg_rdata}, {32'b0, word(4, 4, 0)});
  endtask

  task automatic t_collide;
    cyc(0, 0, 1, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 0, 0, "R9");
    check("R9", "refill dropped", live_vec, 64'h8);
    cyc(0, 0, 1, 0, 1, 6'd10, "R9");
    check("R9", "refill dropped on addressed invalidate", live_vec, 64'h8);
  endtask

  task automatic t_inv_one;
    cyc(0, 0, 1, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, 6'd3, "R5");
    check("R5", "kept slot 3 cleared", {62'b0, live_vec[3], keep_vec[3]}, 64'd0);
    check("R5", "slot 4 untouched", {63'b0, live_vec[4]}, 64'd1);
  endtask

  task automatic t_write_collide;
    cyc(1, word(8, 20, 1), 0, 0, 0, 0, "R11");
    cyc(1, word(2, 40, 0), 1, 0, 0, 0, "R11");
    check("R11", "old pointer slot loaded kept", {62'b0, live_vec[20], keep_vec[20]}, 64'd3);
    check("R11", "written pointer wins", {58'b0, victim_idx}, 64'd40);
    cyc(1, word(5, 50, 0), 0, 1, 0, 0, "R11");
    check("R11", "write beats reload", {58'b0, victim_idx}, 64'd50);
    cyc(0, 0, 0, 0, 1, 6'd20, "R6");
    check("R6", "pointer to floor 5", {58'b0, victim_idx}, 64'd5);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_register();
    t_fill();
    t_lower_ptr();
    t_wrap();
    t_inv_all();
    t_collide();
    t_inv_one();
    t_write_collide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule